// File: doc/BRIEF.md
# Restoring Doubleword Divider

This unit divides an unsigned dividend of two words (a high word and a low word) by an unsigned one-word divisor. It returns a one-word quotient and a one-word remainder. It runs the shift-and-subtract method one step per clock. The partial remainder is 33 bits wide: the bit shifted out of the upper word sits above that word. Each step makes a 33-bit trial subtraction of the divisor, and the difference is kept only when it is not negative. No add-back cycle is ever spent.

A caller places the operands on `hi`, `lo` and `divisor` and raises `start` for one cycle while the unit is idle. Exactly 32 clocks later the unit raises `done` for a single cycle. The registered results then stay on `quotient` and `remainder` until the next operation completes. When the high word is not below the divisor, the quotient cannot fit in one word. In that case, and for a zero divisor, the unit does not trap. It returns the values that the register-level procedure defines.

Top module: `dword_restoring_div`

## Requirements
- R1: After a synchronous active-high reset, `done` is 0 and `quotient` and `remainder` are 0.
- R2: When `hi < divisor`, `quotient` equals floor({hi,lo}/divisor) and `remainder` equals {hi,lo} mod divisor.
- R3: A `start` sampled while idle produces a `done` that is high only in the cycle following the 32nd clock edge after the start edge, and for exactly one cycle.
- R4: With `divisor` equal to 0, `quotient` equals the bitwise complement of `hi` and `remainder` equals `lo`.
- R5: When `hi >= divisor` and the divisor is nonzero, the results follow the register procedure. That procedure sets P={0,hi} and Y=lo and repeats 32 times: shift {P,Y} left by one bit, keep the 33-bit P, and form D=P-{0,divisor}. If bit 32 of D is 0, the low 32 bits of D become the new upper word and Y bit 0 becomes 1; otherwise Y bit 0 becomes 0. The quotient is Y and the remainder is the upper 32 bits' low word.
- R6: A `start` raised while an operation is running is ignored. The running result is unchanged, and no additional `done` follows.
- R7: Between two `done` pulses, `quotient` and `remainder` hold their values.
- R8: A reset during an operation abandons it, and no `done` is produced for it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only when idle) |
| hi | input | 32 | Upper word of the dividend |
| lo | input | 32 | Lower word of the dividend |
| divisor | input | 32 | Divisor |
| quotient | output | 32 | Registered quotient |
| remainder | output | 32 | Registered remainder |
| done | output | 1 | One-cycle completion pulse |

## Verification
A wrong step counter shows at the ports right away as a `done` that comes early or late against the fixed 32-cycle latency. The bench checks this on every operation. A fault in the 33-bit compare or in the conditional write-back may stay hidden in ordinary divisions. It appears in the quotient bits of overflow operands, where the carry bit is set while the upper word is at or above the divisor, and in the zero-divisor pattern. Both classes are driven on purpose. A start that leaks into a running operation corrupts that operation's result or adds an extra `done`, and the scoreboard reports either one at the next completion.

// File: rtl/divr_pkg.sv
package divr_pkg;
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } phase_t;
endpackage

// File: rtl/div_step.sv
// One restoring iteration: shift the {carry, upper, lower} value left and
// keep the 33-bit trial difference only when it is non-negative.
module div_step #(
  parameter int W = 32
) (
  input  logic [W-1:0] x_in,
  input  logic [W-1:0] y_in,
  input  logic [W-1:0] z,
  output logic [W-1:0] x_out,
  output logic [W-1:0] y_out
);
  logic [W:0]   part;
  logic [W:0]   diff;
  logic         keep;

  always_comb begin
    part  = {x_in, y_in[W-1]};
    diff  = part - {1'b0, z};
    keep  = ~diff[W];
    x_out = keep ? diff[W-1:0] : part[W-1:0];
    y_out = {y_in[W-2:0], keep};
  end
endmodule

// File: rtl/div_seq.sv
// Step sequencer: accepts start only when idle, counts W iterations.
module div_seq
  import divr_pkg::*;
#(
  parameter int W = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic start,
  output logic busy,
  output logic load,
  output logic last
);
  localparam int CW = (W > 1) ? $clog2(W) : 1;

  phase_t        ph;
  logic [CW-1:0] cnt;

  assign busy = (ph == PH_RUN);
  assign load = start && (ph == PH_IDLE);
  assign last = busy && (cnt == CW'(W - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      ph  <= PH_IDLE;
      cnt <= '0;
    end else if (load) begin
      ph  <= PH_RUN;
      cnt <= '0;
    end else if (busy) begin
      cnt <= cnt + 1'b1;
      if (last) ph <= PH_IDLE;
    end
  end

  // R3
  run_continues_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !last) |=> busy);

  // R3
  run_ends_chk: assert property (@(posedge clk) disable iff (rst)
    last |=> !busy);

  // R6
  start_ignored_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start && !last) |=> (busy && cnt == $past(cnt) + 1'b1));
endmodule

// File: rtl/dword_restoring_div.sv
module dword_restoring_div #(
  parameter int W = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [W-1:0] hi,
  input  logic [W-1:0] lo,
  input  logic [W-1:0] divisor,
  output logic [W-1:0] quotient,
  output logic [W-1:0] remainder,
  output logic         done
);
  logic [W-1:0] x_q, y_q, z_q;
  logic [W-1:0] x_nxt, y_nxt;
  logic         busy, load, last;

  div_seq #(.W(W)) u_seq (
    .clk  (clk),
    .rst  (rst),
    .start(start),
    .busy (busy),
    .load (load),
    .last (last)
  );

  div_step #(.W(W)) u_step (
    .x_in (x_q),
    .y_in (y_q),
    .z    (z_q),
    .x_out(x_nxt),
    .y_out(y_nxt)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      x_q       <= '0;
      y_q       <= '0;
      z_q       <= '0;
      quotient  <= '0;
      remainder <= '0;
      done      <= 1'b0;
    end else begin
      done <= last;
      if (load) begin
        x_q <= hi;
        y_q <= lo;
        z_q <= divisor;
      end else if (busy) begin
        x_q <= x_nxt;
        y_q <= y_nxt;
      end
      if (last) begin
        quotient  <= y_nxt;
        remainder <= x_nxt;
      end
    end
  end

  // R3
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R3
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R7
  result_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !done |-> ($stable(quotient) && $stable(remainder)));

  // R2
  rem_below_div_chk: assert property (@(posedge clk) disable iff (rst)
    (last && x_q < z_q && z_q != '0 && $past(load) == 1'b0) |=> (remainder < z_q));
endmodule

// File: tb/dword_restoring_div_bench.sv
module dword_restoring_div_bench;
  localparam int W = 32;
  localparam int CLK_PERIOD = 10;
  localparam int LAT = 33;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [W-1:0] hi = '0, lo = '0, divisor = '0;
  logic [W-1:0] quotient, remainder;
  logic         done;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  int issued = 0;
  int seen = 0;
  int done_count = 0;
  bit finished = 0;

  logic [2*W-1:0] exp_q[$];
  int             exp_t[$];
  string          exp_tag[$];
  logic [2*W-1:0] last_res = '0;

  dword_restoring_div #(.W(W)) u_dword_restoring_div (
    .clk(clk), .rst(rst), .start(start), .hi(hi), .lo(lo),
    .divisor(divisor), .quotient(quotient), .remainder(remainder), .done(done)
  );

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [2*W-1:0] reg_model(logic [W-1:0] h, logic [W-1:0] l, logic [W-1:0] d);
    logic [W-1:0] x, y;
    logic [W:0]   p, df;
    x = h; y = l;
    for (int i = 0; i < W; i++) begin
      p  = {x, y[W-1]};
      df = p - {1'b0, d};
      y  = {y[W-2:0], ~df[W]};
      x  = df[W] ? p[W-1:0] : df[W-1:0];
    end
    return {y, x};
  endfunction

  task automatic check(bit ok, string tag, logic [2*W-1:0] act, logic [2*W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // Monitor: pops expected results when done appears.
  always @(negedge clk) begin
    if (!rst && done) begin
      done_count++;
      if (exp_q.size() == 0) begin
        check(0, "R6/R8 unexpected done", {quotient, remainder}, '0);
      end else begin
        automatic logic [2*W-1:0] e = exp_q.pop_front();
        automatic int t0 = exp_t.pop_front();
        automatic string tg = exp_tag.pop_front();
        check({quotient, remainder} == e, tg, {quotient, remainder}, e);
        check(cyc == t0 + LAT, "R3 latency", 64'(cyc - t0), 64'(LAT));
        last_res = {quotient, remainder};
      end
      seen++;
    end
  end

  task automatic launch(logic [W-1:0] h, logic [W-1:0] l, logic [W-1:0] d,
                        logic [2*W-1:0] e, string tag);
    @(negedge clk);
    hi = h; lo = l; divisor = d; start = 1'b1;
    exp_q.push_back(e); exp_t.push_back(cyc); exp_tag.push_back(tag);
    issued++;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic run_op(logic [W-1:0] h, logic [W-1:0] l, logic [W-1:0] d,
                        logic [2*W-1:0] e, string tag);
    launch(h, l, d, e, tag);
    while (seen < issued) @(negedge clk);
  endtask

  task automatic run_true(logic [W-1:0] h, logic [W-1:0] l, logic [W-1:0] d);
    logic [2*W-1:0] n;
    n = {h, l};
    run_op(h, l, d, {W'(n / {32'd0, d}), W'(n % {32'd0, d})}, "R2 exact division");
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    check(0, "watchdog", '0, '0);
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check(done == 1'b0 && quotient == '0 && remainder == '0, "R1 reset state",
          {quotient, remainder}, '0);

    // R2 edge and random operands
    run_true(32'h0, 32'd100, 32'd7);
    run_true(32'h0, 32'hFFFF_FFFF, 32'd1);
    run_true(32'hFFFF_FFFE, 32'hFFFF_FFFF, 32'hFFFF_FFFF);
    run_true(32'h7FFF_FFFF, 32'h1234_5678, 32'h8000_0000);
    run_true(32'h0, 32'd5, 32'd9);
    for (int i = 0; i < 12; i++) begin
      automatic logic [W-1:0] d = $urandom | 32'h1;
      automatic logic [W-1:0] h = $urandom % d;
      run_true(h, $urandom, d);
    end

    // R4 zero divisor
    run_op(32'h1234_5678, 32'h9ABC_DEF0, 32'h0, {~32'h1234_5678, 32'h9ABC_DEF0}, "R4 zero divisor");
    run_op(32'h0, 32'hFFFF_0000, 32'h0, {32'hFFFF_FFFF, 32'hFFFF_0000}, "R4 zero divisor");

    // R5 overflow operands
    run_op(32'd9, 32'd3, 32'd9, reg_model(32'd9, 32'd3, 32'd9), "R5 overflow");
    run_op(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd3, reg_model(32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'd3), "R5 overflow");
    run_op(32'hC000_0001, 32'h8765_4321, 32'h8000_0000,
           reg_model(32'hC000_0001, 32'h8765_4321, 32'h8000_0000), "R5 overflow");

    // R6 start during an operation is ignored
    begin
      automatic int dc;
      launch(32'h0, 32'd1000, 32'd10, {32'd100, 32'd0}, "R6 start ignored while busy");
      repeat (5) @(negedge clk);
      hi = 32'h5; lo = 32'h5; divisor = 32'h0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      while (seen < issued) @(negedge clk);
      dc = done_count;
      repeat (40) @(negedge clk);
      check(done_count == dc, "R6 no extra done", 64'(done_count), 64'(dc));
    end

    // R7 results hold after done
    repeat (7) @(negedge clk);
    check({quotient, remainder} == last_res, "R7 result hold", {quotient, remainder}, last_res);

    // R8 reset mid-operation
    begin
      automatic int dc;
      @(negedge clk);
      hi = 32'h0; lo = 32'd77; divisor = 32'd7; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      rst = 1'b1;
      repeat (2) @(negedge clk);
      rst = 1'b0;
      dc = done_count;
      check(done == 1'b0 && quotient == '0 && remainder == '0, "R1 reset state after abort",
            {quotient, remainder}, '0);
      repeat (40) @(negedge clk);
      check(done_count == dc, "R8 no done after abort", 64'(done_count), 64'(dc));
    end

    // unit still works after abort
    run_true(32'h0, 32'd77, 32'd7);
    finish_run();
  end
endmodule